// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block brings an SDRAM device out of power-up and then keeps it refreshed on behalf of a simple memory controller. Once `enable` goes high it counts a programmable start-up delay. It then issues the three initialization commands in a fixed order: precharge of all banks, one auto-refresh, and a mode-register load. A programmable gap follows each of these commands. When the mode-register gap has expired it raises `initDone`.

From then on a period counter makes a refresh due every `refreshPeriod` cycles. Each due refresh goes into a small backlog. The sequencer requests the bus with `cmdReq` and issues a command only in a cycle where the access engine's `memBusy` is low. While a command and its gap are in progress, the sequencer holds `schedBusy` high towards the access engine. If refreshes fall due while the bus is taken, up to four of them are kept. They are issued one after another, each followed by the row-cycle gap, as soon as the bus is free. A refresh that falls due when the backlog is already full is dropped and sets a sticky overflow flag.

Commands leave on a one-hot, one-cycle pulse: bit 0 is precharge-all, bit 1 is auto-refresh, bit 2 is mode-register load.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is active, and while `enable` is low, `cmdOut` is 0, `initDone` is 0, `schedBusy` is 0 and `overflow` is 0.
- R2: With `memBusy` low, the precharge-all pulse (cmdOut = 3'b001) appears on clock edge `startDelay`+3, counting as edge 1 the first edge at which `enable` is sampled high.
- R3: The initialization commands appear in the order precharge-all (3'b001), auto-refresh (3'b010), mode-register load (3'b100). Every command is a single-cycle pulse, and `cmdOut` has at most one bit set.
- R4: With `memBusy` low, a command follows the previous one by the previous command's gap plus 2 cycles. The gap after precharge is `prechGap`, the gap after any auto-refresh is `rowCycGap`. `initDone` rises `mrdGap`+1 cycles after the mode-register pulse.
- R5: No command is issued in a cycle where `memBusy` is high. While a command is pending, `cmdReq` is high, and the command appears one cycle after `memBusy` falls.
- R6: After `initDone` rises, with `refreshPeriod` = P > 0 and `memBusy` low, the first auto-refresh pulse comes P+1 cycles after `initDone` rises, and later ones follow every P cycles.
- R7: With `refreshPeriod` = 0, no auto-refresh is issued after initialization.
- R8: Refreshes that fall due while `memBusy` is high are held, up to four. They are issued starting one cycle after `memBusy` falls, spaced `rowCycGap`+2 cycles apart.
- R9: A refresh falling due while four are already held is discarded, and `overflow` goes high and stays high until `enable` drops or reset.
- R10: Dropping `enable` returns the block to idle on the next edge. `initDone` and `overflow` clear, the backlog clears, and after re-enabling the first command is precharge-all, not a stale refresh.
- R11: `schedBusy` is high in every cycle from the precharge pulse until `initDone` rises. It is high for exactly `rowCycGap`+1 cycles starting with each run-time refresh pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Starts the sequence; low returns to idle |
| startDelay | input | 14 | Start-up delay in cycles |
| refreshPeriod | input | 10 | Refresh interval in cycles; 0 disables refresh |
| prechGap | input | 3 | Extra gap after precharge-all |
| rowCycGap | input | 3 | Extra gap after each auto-refresh |
| mrdGap | input | 2 | Extra gap after mode-register load |
| memBusy | input | 1 | Access engine holds the memory bus |
| cmdReq | output | 1 | Sequencer has a command waiting for the bus |
| schedBusy | output | 1 | Sequencer occupies the bus |
| cmdOut | output | 3 | One-hot command pulse: bit0 precharge, bit1 refresh, bit2 mode load |
| initDone | output | 1 | Initialization complete |
| overflow | output | 1 | Sticky: a refresh was dropped because the backlog was full |

## Verification
The hardest state to reach is a full backlog followed by a fifth refresh that must be dropped. That state needs `memBusy` held high across several refresh periods after initialization, and then released at a moment that is not close to the next period tick. The stimulus uses a long period of 100 cycles. It holds the bus once for three periods and checks an exact three-pulse drain. It then holds the bus for nearly six periods, so that exactly four pulses drain and `overflow` is set. The backlog is then filled again and `enable` is dropped, which shows that the held refreshes are discarded rather than issued after re-enabling.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_PRE, ST_REF, ST_MRS, ST_RUN, ST_GAP
  } seqStateT;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_PRE = 3'b001;
  localparam logic [CMD_W-1:0] CMD_REF = 3'b010;
  localparam logic [CMD_W-1:0] CMD_MRS = 3'b100;

  localparam logic [1:0] GSEL_PRE = 2'd0;
  localparam logic [1:0] GSEL_ROW = 2'd1;
  localparam logic [1:0] GSEL_MRD = 2'd2;

  typedef struct packed {
    logic       clear;
    logic       waitRun;
    logic       loadGap;
    logic [1:0] gapSel;
    logic       gapDec;
    logic       pop;
    logic       runOn;
  } seqStrobeT;

  typedef struct packed {
    logic waitDone;
    logic gapZero;
    logic pending;
  } seqStatusT;
endpackage

// File: rtl/sdr_seq_dp.sv
module sdr_seq_dp
  import sdr_seq_pkg::*;
#(
  parameter int DLY_W   = 14,
  parameter int PER_W   = 10,
  parameter int PRE_W   = 3,
  parameter int ROW_W   = 3,
  parameter int MRD_W   = 2,
  parameter int BACKLOG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        stb,
  input  logic [DLY_W-1:0] startDelay,
  input  logic [PER_W-1:0] refreshPeriod,
  input  logic [PRE_W-1:0] prechGap,
  input  logic [ROW_W-1:0] rowCycGap,
  input  logic [MRD_W-1:0] mrdGap,
  output seqStatusT        sts,
  output logic             overflow
);
  localparam int GA_W  = (PRE_W > ROW_W) ? PRE_W : ROW_W;
  localparam int GAP_W = (GA_W > MRD_W) ? GA_W : MRD_W;
  localparam int BL_W  = $clog2(BACKLOG + 1);
  localparam logic [BL_W-1:0] BL_FULL = BL_W'(BACKLOG);

  logic [DLY_W-1:0] waitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [PER_W-1:0] perCnt;
  logic [BL_W-1:0]  backlog;
  logic             tick;

  assign tick = stb.runOn && (refreshPeriod != '0) &&
                (perCnt >= refreshPeriod - PER_W'(1));

  assign sts.waitDone = (waitCnt == startDelay);
  assign sts.gapZero  = (gapCnt == '0);
  assign sts.pending  = (backlog != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      gapCnt   <= '0;
      perCnt   <= '0;
      backlog  <= '0;
      overflow <= 1'b0;
    end else if (stb.clear) begin
      waitCnt  <= '0;
      gapCnt   <= '0;
      perCnt   <= '0;
      backlog  <= '0;
      overflow <= 1'b0;
    end else begin
      if (stb.waitRun && !sts.waitDone) waitCnt <= waitCnt + DLY_W'(1);

      if (stb.loadGap) begin
        case (stb.gapSel)
          GSEL_PRE: gapCnt <= GAP_W'(prechGap);
          GSEL_ROW: gapCnt <= GAP_W'(rowCycGap);
          default:  gapCnt <= GAP_W'(mrdGap);
        endcase
      end else if (stb.gapDec && !sts.gapZero) begin
        gapCnt <= gapCnt - GAP_W'(1);
      end

      if (stb.runOn) perCnt <= tick ? '0 : perCnt + PER_W'(1);

      case ({tick, stb.pop})
        2'b10: begin
          if (backlog == BL_FULL) overflow <= 1'b1;
          else backlog <= backlog + BL_W'(1);
        end
        2'b01:   backlog <= backlog - BL_W'(1);
        default: backlog <= backlog;
      endcase
    end
  end

  // R8: the backlog never holds more than the configured depth
  p_backlog_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    backlog <= BL_FULL);

  // R9: overflow is sticky until cleared
  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !stb.clear) |=> overflow);

  // R8: a pop is only requested when something is held
  p_pop_needs_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> backlog != '0);
endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             memBusy,
  input  seqStatusT        sts,
  output seqStrobeT        stb,
  output logic             cmdReq,
  output logic             schedBusy,
  output logic [CMD_W-1:0] cmdOut,
  output logic             initDone
);
  seqStateT         state, retState;
  logic             issue;
  logic [CMD_W-1:0] cmdR;
  logic             doneR;

  assign cmdReq = (state == ST_PRE) || (state == ST_REF) || (state == ST_MRS) ||
                  ((state == ST_RUN) && sts.pending);
  assign issue  = cmdReq && !memBusy;

  always_comb begin
    stb         = '0;
    stb.clear   = !enable || (state == ST_IDLE);
    stb.waitRun = (state == ST_WAIT);
    stb.loadGap = issue;
    stb.gapDec  = (state == ST_GAP);
    stb.pop     = (state == ST_RUN) && issue;
    stb.runOn   = doneR;
    case (state)
      ST_PRE:  stb.gapSel = GSEL_PRE;
      ST_MRS:  stb.gapSel = GSEL_MRD;
      default: stb.gapSel = GSEL_ROW;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retState <= ST_IDLE;
      cmdR     <= '0;
      doneR    <= 1'b0;
    end else if (!enable) begin
      state    <= ST_IDLE;
      retState <= ST_IDLE;
      cmdR     <= '0;
      doneR    <= 1'b0;
    end else begin
      cmdR <= '0;
      case (state)
        ST_IDLE: state <= ST_WAIT;
        ST_WAIT: if (sts.waitDone) state <= ST_PRE;
        ST_PRE: if (issue) begin
          cmdR <= CMD_PRE; state <= ST_GAP; retState <= ST_REF;
        end
        ST_REF: if (issue) begin
          cmdR <= CMD_REF; state <= ST_GAP; retState <= ST_MRS;
        end
        ST_MRS: if (issue) begin
          cmdR <= CMD_MRS; state <= ST_GAP; retState <= ST_RUN;
        end
        ST_RUN: if (issue) begin
          cmdR <= CMD_REF; state <= ST_GAP; retState <= ST_RUN;
        end
        ST_GAP: if (sts.gapZero) begin
          state <= retState;
          if (retState == ST_RUN) doneR <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmdOut    = cmdR;
  assign initDone  = doneR;
  assign schedBusy = (state == ST_GAP) || (state == ST_REF) || (state == ST_MRS);

  // R3: command output is one-hot or idle
  p_cmd_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdOut));

  // R3: every command lasts a single cycle
  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != '0) |=> (cmdOut == '0));

  // R5: no command follows a cycle where the bus was held
  p_no_cmd_when_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    memBusy |=> (cmdOut == '0));

  // R10: dropping enable drops initDone
  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !initDone);
endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int DLY_W   = 14,
  parameter int PER_W   = 10,
  parameter int PRE_W   = 3,
  parameter int ROW_W   = 3,
  parameter int MRD_W   = 2,
  parameter int BACKLOG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DLY_W-1:0] startDelay,
  input  logic [PER_W-1:0] refreshPeriod,
  input  logic [PRE_W-1:0] prechGap,
  input  logic [ROW_W-1:0] rowCycGap,
  input  logic [MRD_W-1:0] mrdGap,
  input  logic             memBusy,
  output logic             cmdReq,
  output logic             schedBusy,
  output logic [2:0]       cmdOut,
  output logic             initDone,
  output logic             overflow
);
  seqStrobeT stb;
  seqStatusT sts;

  sdr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .memBusy(memBusy),
    .sts(sts), .stb(stb), .cmdReq(cmdReq), .schedBusy(schedBusy),
    .cmdOut(cmdOut), .initDone(initDone)
  );

  sdr_seq_dp #(
    .DLY_W(DLY_W), .PER_W(PER_W), .PRE_W(PRE_W),
    .ROW_W(ROW_W), .MRD_W(MRD_W), .BACKLOG(BACKLOG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startDelay(startDelay),
    .refreshPeriod(refreshPeriod), .prechGap(prechGap),
    .rowCycGap(rowCycGap), .mrdGap(mrdGap), .sts(sts), .overflow(overflow)
  );
endmodule

// File: tb/sim_sdram_init_refresh.sv
module sim_sdram_init_refresh;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [13:0] startDelay = '0;
  logic [9:0]  refreshPeriod = '0;
  logic [2:0]  prechGap = '0;
  logic [2:0]  rowCycGap = '0;
  logic [1:0]  mrdGap = '0;
  logic        memBusy = 1'b0;
  logic        cmdReq, schedBusy, initDone, overflow;
  logic [2:0]  cmdOut;

  int tests = 0;
  int failed = 0;
  bit sawIdle;

  always #5 clk = ~clk;

  sdram_init_refresh u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .startDelay(startDelay),
    .refreshPeriod(refreshPeriod), .prechGap(prechGap), .rowCycGap(rowCycGap),
    .mrdGap(mrdGap), .memBusy(memBusy), .cmdReq(cmdReq), .schedBusy(schedBusy),
    .cmdOut(cmdOut), .initDone(initDone), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic waitCmd(input int limit, output int n, output logic [2:0] c);
    n = 0; c = '0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (!schedBusy) sawIdle = 1'b1;
      if (cmdOut != '0) begin
        c = cmdOut;
        break;
      end
    end
  endtask

  task automatic doInit(input int d, input int rp, input int rc, input int mrd, input int per);
    int n, k;
    logic [2:0] c;
    enable = 1'b0; memBusy = 1'b0;
    repeat (2) @(negedge clk);
    startDelay = 14'(d); prechGap = 3'(rp); rowCycGap = 3'(rc);
    mrdGap = 2'(mrd); refreshPeriod = 10'(per);
    enable = 1'b1;
    waitCmd(d + 10, n, c);
    chk(c == 3'b001, "R3 first command precharge", c, 1);
    chk(n == d + 3, "R2 start delay to precharge", n, d + 3);
    sawIdle = 1'b0;
    waitCmd(rp + 10, n, c);
    chk(c == 3'b010, "R3 second command refresh", c, 2);
    chk(n == rp + 2, "R4 precharge gap", n, rp + 2);
    waitCmd(rc + 10, n, c);
    chk(c == 3'b100, "R3 third command mode load", c, 4);
    chk(n == rc + 2, "R4 row-cycle gap in init", n, rc + 2);
    k = 0;
    while (k < 20) begin
      @(negedge clk);
      k++;
      if (initDone) break;
      if (!schedBusy) sawIdle = 1'b1;
    end
    chk(k == mrd + 1, "R4 mode gap to initDone", k, mrd + 1);
    chk(!sawIdle, "R11 schedBusy held through init", sawIdle, 0);
  endtask

  task automatic drain(input int expN, input int rc);
    int k = 0;
    for (int i = 1; i <= expN * (rc + 2) + 4; i++) begin
      @(negedge clk);
      if (cmdOut != '0) begin
        chk(cmdOut == 3'b010 && i == 1 + k * (rc + 2), "R8 backlog drain timing",
            i, 1 + k * (rc + 2));
        k++;
      end
    end
    chk(k == expN, "R8 backlog drain count", k, expN);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmdOut == '0 && !initDone && !schedBusy && !overflow, "R1 reset outputs",
        {cmdOut, initDone, schedBusy, overflow}, 0);
    rstN = 1'b1;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmdOut == '0 && !initDone && !schedBusy && !overflow, "R1 disabled outputs",
        {cmdOut, initDone, schedBusy, overflow}, 0);
  endtask

  task automatic t_grant;
    int n;
    logic [2:0] c;
    enable = 1'b0;
    repeat (2) @(negedge clk);
    startDelay = 14'd2; memBusy = 1'b1;
    enable = 1'b1;
    waitCmd(20, n, c);
    chk(c == '0, "R5 no command while memBusy", c, 0);
    chk(cmdReq == 1'b1, "R5 request raised while waiting", cmdReq, 1);
    memBusy = 1'b0;
    waitCmd(5, n, c);
    chk(c == 3'b001 && n == 1, "R5 command on first free cycle", n, 1);
  endtask

  task automatic t_periodic;
    int n, k;
    logic [2:0] c;
    doInit(4, 2, 3, 1, 40);
    waitCmd(60, n, c);
    chk(c == 3'b010 && n == 41, "R6 first refresh after initDone", n, 41);
    k = 0;
    while (k < 20) begin
      @(negedge clk);
      k++;
      if (!schedBusy) break;
    end
    chk(k == 4, "R11 schedBusy length per refresh", k, 4);
    waitCmd(60, n, c);
    chk(c == 3'b010 && n + k == 40, "R6 refresh interval", n + k, 40);
    waitCmd(60, n, c);
    chk(c == 3'b010 && n == 40, "R6 refresh interval repeat", n, 40);
  endtask

  task automatic t_zero_period;
    int n;
    logic [2:0] c;
    doInit(0, 0, 0, 0, 0);
    waitCmd(300, n, c);
    chk(c == '0, "R7 no refresh with zero period", c, 0);
  endtask

  task automatic t_backlog;
    doInit(1, 1, 2, 0, 100);
    memBusy = 1'b1;
    repeat (350) @(negedge clk);
    chk(!overflow, "R9 no overflow at three held", overflow, 0);
    memBusy = 1'b0;
    drain(3, 2);
    memBusy = 1'b1;
    repeat (580) @(negedge clk);
    memBusy = 1'b0;
    drain(4, 2);
    chk(overflow, "R9 overflow after fifth due refresh", overflow, 1);
    repeat (10) @(negedge clk);
    chk(overflow, "R9 overflow stays set", overflow, 1);
  endtask

  task automatic t_disable;
    int n;
    logic [2:0] c;
    memBusy = 1'b1;
    repeat (250) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!initDone && !overflow && cmdOut == '0, "R10 disable clears flags",
        {initDone, overflow}, 0);
    memBusy = 1'b0;
    waitCmd(5, n, c);
    chk(c == '0, "R10 no stale refresh while disabled", c, 0);
    startDelay = 14'd3;
    enable = 1'b1;
    waitCmd(20, n, c);
    chk(c == 3'b001 && n == 6, "R10 restart begins with precharge", c, 1);
  endtask

  initial begin
    #2000000;
    failed++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    t_reset();
    t_grant();
    t_periodic();
    t_zero_period();
    t_backlog();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule